// File: doc/BRIEF.md
# Debug Command Register and Dispatcher

This block is the instruction register of a debug port that sits behind a standard JTAG TAP state machine. It takes strobes from the TAP for the IR and DR capture, shift and update states. A 10-bit command is shifted in from `tdi`, least significant bit first. The command becomes the active command only at Update-IR. The active command holds four fields: a read/write flag, a single-step request, a debug-exit request and a 7-bit register-select code. The select code is decoded into one-hot select lines for ten debug data registers.

None of the work the command asks for happens at Update-IR. The access strobe for the selected register and the single-step and exit pulses are all issued at the next Update-DR. This holds even when the select code names no data register. Further Update-DR passes repeat the same command until a new Update-IR loads another one. The block holds only two data registers itself: a one-bit bypass stage and a read-only identification register. For any other selected register, the serial output of that register is passed from `ext_tdo` to `tdo`.

Top module: `dbgcmd_top`

## Requirements
- R1: After reset, the active command is read flag 0, step 0, exit 0 and select code 0x1B. No select line is high, all strobes and pulses are low, and `tdo` is 0.
- R2: A Capture-IR cycle loads 0b0000000001 into the IR shift stage. While `shift_ir` is high, `tdo` shows the least significant bit of the stage. Each shift edge moves the stage toward `tdo` and enters `tdi` at the most significant bit.
- R3: The active command changes only on a clock edge with `update_ir` high. It then takes the whole shift stage. Capturing or shifting without an update leaves it unchanged.
- R4: Command field positions: bit 9 is the read flag (1 = read, 0 = write), bit 8 is step (go), bit 7 is exit, and bits 6..0 are the select code.
- R5: Select decode: 0x02 drives `reg_sel[0]` (ID), 0x10 drives `reg_sel[1]` (CPU scan), 0x12 drives `reg_sel[2]` (control), 0x20..0x23 drive `reg_sel[3..6]` (instruction compare 1..4), 0x24..0x25 drive `reg_sel[7..8]` (data address compare 1..2), and 0x26 drives `reg_sel[9]` (data value compare). At most one line is high.
- R6: Every other select code, including 0x11, uses the bypass path. Capture-DR loads 0. During Shift-DR, `tdo` gives `tdi` delayed by one shift.
- R7: With code 0x02 selected, Capture-DR loads the identification value. Shift-DR then presents it on `tdo` least significant bit first.
- R8: In the cycle after an Update-DR edge, exactly one of the following happens for one cycle. `rd_stb` is high if a register is selected and the read flag is 1. `wr_stb` is high if a register is selected and the read flag is 0. Neither is high for bypass codes.
- R9: `go_pulse` and `ex_pulse` follow the step and exit fields. Each is high for one cycle after an Update-DR edge, whatever the select code. Neither fires at Update-IR.
- R10: A write command to the ID register (code 0x02, read flag 0) produces no `wr_stb`.
- R11: A second Update-DR with no Update-IR in between repeats the same strobes and pulses.
- R12: While Shift-DR is active and a register other than ID is selected, `tdo` follows `ext_tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | 1 | Serial output of the selected external register |
| tdo | output | 1 | Serial data out |
| cmd_rw | output | 1 | Active read flag |
| cmd_go | output | 1 | Active step field |
| cmd_ex | output | 1 | Active exit field |
| cmd_rs | output | 7 | Active select code |
| reg_sel | output | 10 | One-hot register selects |
| rd_stb | output | 1 | Read access strobe |
| wr_stb | output | 1 | Write access strobe |
| go_pulse | output | 1 | Single-step pulse |
| ex_pulse | output | 1 | Debug exit pulse |

## Verification
The decoder is tried with all 128 select codes. This separates the ten listed codes from the reserved and unlisted codes that must fall back to bypass. DR scans are run with four kinds of selection: bypass (a shifted byte whose one-shift delay is checked), the ID register (the 32-bit value read back), an external register with read and with write commands, and a write to ID. Together these show which access strobe fires and which one is suppressed. Step and exit commands are scanned twice in a row. This checks that nothing fires at Update-IR and that each Update-DR repeats the pulses.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

    localparam int CMD_W = 10;
    localparam int RS_W  = 7;
    localparam int NSEL  = 10;
    localparam int SEL_ID = 0;

    localparam logic [CMD_W-1:0] CMD_RESET  = 10'b00_0001_1011;
    localparam logic [CMD_W-1:0] IR_CAPTURE = 10'b00_0000_0001;

    typedef struct packed {
        logic            rw;
        logic            go;
        logic            ex;
        logic [RS_W-1:0] rs;
    } cmd_t;

    // select code that drives select line idx
    function automatic logic [RS_W-1:0] sel_code(input int idx);
        logic [RS_W-1:0] c;
        case (idx)
            0:       c = 7'h02;
            1:       c = 7'h10;
            2:       c = 7'h12;
            default: c = 7'h20 + RS_W'(idx - 3);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbgcmd_ir.sv
module dbgcmd_ir
    import dbgcmd_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic ser_out,
    output cmd_t cmd
);

    typedef struct packed {
        logic [CMD_W-1:0] sh;
        cmd_t             act;
    } ir_st_t;

    ir_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.sh = IR_CAPTURE;
        end else if (shift) begin
            st_d.sh = {tdi, st_q.sh[CMD_W-1:1]};
        end
        if (update) begin
            st_d.act = cmd_t'(st_q.sh);
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= CMD_RESET;
            st_q.act <= cmd_t'(CMD_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.sh[0];
    assign cmd     = st_q.act;

    AST_CMD_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
        !update |=> $stable(cmd)); // R3
    AST_IR_CAPTURE_LSB: assert property (@(posedge tck) disable iff (!rst_n)
        capture |=> (ser_out == 1'b1)); // R2

endmodule

// File: rtl/dbgcmd_decode.sv
module dbgcmd_decode
    import dbgcmd_pkg::*;
(
    input  logic [RS_W-1:0] rs,
    output logic [NSEL-1:0] sel,
    output logic            hit,
    output logic            is_id
);

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel[g] = (rs == sel_code(g));
    end

    assign hit   = |sel;
    assign is_id = sel[SEL_ID];

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(sel)); // R5
    end

endmodule

// File: rtl/dbgcmd_dr.sv
module dbgcmd_dr #(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = '1
) (
    input  logic tck,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic shift_ir,
    input  logic ir_ser,
    input  logic tdi,
    input  logic hit,
    input  logic is_id,
    input  logic ext_tdo,
    output logic tdo
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id_sh;
    } dr_st_t;

    dr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            if (is_id) st_d.id_sh = ID_VALUE;
            if (!hit)  st_d.byp   = 1'b0;
        end else if (shift) begin
            if (is_id) st_d.id_sh = {tdi, st_q.id_sh[ID_W-1:1]};
            if (!hit)  st_d.byp   = tdi;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q.byp   <= 1'b0;
            st_q.id_sh <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (shift_ir) begin
            tdo = ir_ser;
        end else if (shift) begin
            if (is_id)    tdo = st_q.id_sh[0];
            else if (hit) tdo = ext_tdo;
            else          tdo = st_q.byp;
        end else begin
            tdo = 1'b0;
        end
    end

    AST_BYPASS_ONE_STAGE: assert property (@(posedge tck) disable iff (!rst_n)
        (shift && !hit && !capture) |=> (st_q.byp == $past(tdi))); // R6
    AST_BYPASS_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
        (capture && !hit) |=> (st_q.byp == 1'b0)); // R6

endmodule

// File: rtl/dbgcmd_strobe.sv
module dbgcmd_strobe (
    input  logic tck,
    input  logic rst_n,
    input  logic update_dr,
    input  logic rw,
    input  logic go,
    input  logic ex,
    input  logic hit,
    input  logic is_id,
    output logic rd_stb,
    output logic wr_stb,
    output logic go_pulse,
    output logic ex_pulse
);

    typedef struct packed {
        logic udr;
        logic rd;
        logic wr;
        logic go;
        logic ex;
    } stb_st_t;

    stb_st_t st_d, st_q;
    logic    fire;

    assign fire = update_dr && !st_q.udr;

    always_comb begin
        st_d     = '0;
        st_d.udr = update_dr;
        if (fire) begin
            st_d.rd = hit && rw;
            st_d.wr = hit && !rw && !is_id;
            st_d.go = go;
            st_d.ex = ex;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stb   = st_q.rd;
    assign wr_stb   = st_q.wr;
    assign go_pulse = st_q.go;
    assign ex_pulse = st_q.ex;

    AST_GO_ONE_CYCLE: assert property (@(posedge tck) disable iff (!rst_n)
        go_pulse |=> !go_pulse); // R9
    AST_EX_ONE_CYCLE: assert property (@(posedge tck) disable iff (!rst_n)
        ex_pulse |=> !ex_pulse); // R9
    AST_ACCESS_AFTER_UDR: assert property (@(posedge tck) disable iff (!rst_n)
        (rd_stb || wr_stb || go_pulse || ex_pulse) |-> $past(update_dr)); // R8
    AST_RD_WR_EXCL: assert property (@(posedge tck) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R8
    AST_NO_ID_WRITE: assert property (@(posedge tck) disable iff (!rst_n)
        wr_stb |-> !$past(is_id)); // R10

endmodule

// File: rtl/dbgcmd_top.sv
module dbgcmd_top
    import dbgcmd_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_001D
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    input  logic            ext_tdo,
    output logic            tdo,
    output logic            cmd_rw,
    output logic            cmd_go,
    output logic            cmd_ex,
    output logic [RS_W-1:0] cmd_rs,
    output logic [NSEL-1:0] reg_sel,
    output logic            rd_stb,
    output logic            wr_stb,
    output logic            go_pulse,
    output logic            ex_pulse
);

    cmd_t cmd;
    logic ir_ser;
    logic hit;
    logic is_id;

    dbgcmd_ir u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .capture (capture_ir),
        .shift   (shift_ir),
        .update  (update_ir),
        .tdi     (tdi),
        .ser_out (ir_ser),
        .cmd     (cmd)
    );

    dbgcmd_decode u_dec (
        .rs    (cmd.rs),
        .sel   (reg_sel),
        .hit   (hit),
        .is_id (is_id)
    );

    dbgcmd_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .shift_ir (shift_ir),
        .ir_ser   (ir_ser),
        .tdi      (tdi),
        .hit      (hit),
        .is_id    (is_id),
        .ext_tdo  (ext_tdo),
        .tdo      (tdo)
    );

    dbgcmd_strobe u_stb (
        .tck       (tck),
        .rst_n     (rst_n),
        .update_dr (update_dr),
        .rw        (cmd.rw),
        .go        (cmd.go),
        .ex        (cmd.ex),
        .hit       (hit),
        .is_id     (is_id),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .go_pulse  (go_pulse),
        .ex_pulse  (ex_pulse)
    );

    assign cmd_rw = cmd.rw;
    assign cmd_go = cmd.go;
    assign cmd_ex = cmd.ex;
    assign cmd_rs = cmd.rs;

    AST_STROBE_NEEDS_SELECT: assert property (@(posedge tck) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> (reg_sel != '0)); // R8

endmodule

// File: tb/dbgcmd_top_tb_top.sv
module dbgcmd_top_tb_top;

    localparam logic [31:0] IDV = 32'h1A5C_001D;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_ir = 0, shift_ir = 0, update_ir = 0;
    logic       capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic       tdi = 0, ext_tdo = 0;
    logic       tdo, cmd_rw, cmd_go, cmd_ex;
    logic [6:0] cmd_rs;
    logic [9:0] reg_sel;
    logic       rd_stb, wr_stb, go_pulse, ex_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #5 tck = ~tck;

    dbgcmd_top #(.ID_W(32), .ID_VALUE(IDV)) dut_i (
        .tck(tck), .rst_n(rst_n),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .ext_tdo(ext_tdo), .tdo(tdo),
        .cmd_rw(cmd_rw), .cmd_go(cmd_go), .cmd_ex(cmd_ex), .cmd_rs(cmd_rs),
        .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .go_pulse(go_pulse), .ex_pulse(ex_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        @(negedge tck);
    endtask

    function automatic logic [9:0] exp_sel(input logic [6:0] rs);
        logic [9:0] s = '0;
        if (rs == 7'h02) s[0] = 1'b1;
        else if (rs == 7'h10) s[1] = 1'b1;
        else if (rs == 7'h12) s[2] = 1'b1;
        else if (rs >= 7'h20 && rs <= 7'h26) s[3 + int'(rs - 7'h20)] = 1'b1;
        return s;
    endfunction

    function automatic logic [3:0] stb_now();
        return {rd_stb, wr_stb, go_pulse, ex_pulse};
    endfunction

    task automatic ir_scan(input logic [9:0] val, input bit do_upd, output logic [9:0] outv);
        capture_ir = 1; cyc(); capture_ir = 0;
        shift_ir = 1;
        for (int i = 0; i < 10; i++) begin
            tdi = val[i]; #1;
            outv[i] = tdo;
            cyc();
        end
        shift_ir = 0;
        if (do_upd) begin
            update_ir = 1; cyc(); update_ir = 0;
        end
    endtask

    task automatic dr_scan(input int n, input logic [31:0] val, output logic [31:0] outv,
                           output logic [3:0] s1, output logic [3:0] s2);
        outv = '0;
        capture_dr = 1; cyc(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < n; i++) begin
            tdi = val[i]; #1;
            outv[i] = tdo;
            cyc();
        end
        shift_dr = 0;
        update_dr = 1; cyc(); update_dr = 0;
        s1 = stb_now();
        cyc();
        s2 = stb_now();
    endtask

    task automatic t_reset();
        check("R1 rw", 32'(cmd_rw), 0);
        check("R1 go/ex", {30'd0, cmd_go, cmd_ex}, 0);
        check("R1 rs", 32'(cmd_rs), 32'h1B);
        check("R1 sel", 32'(reg_sel), 0);
        check("R1 strobes", 32'(stb_now()), 0);
        check("R1 tdo", 32'(tdo), 0);
    endtask

    task automatic t_ir_capture_and_hold();
        logic [9:0] o;
        ir_scan({1'b1, 1'b0, 1'b0, 7'h10}, 1'b0, o);
        check("R2 capture pattern", 32'(o), 32'h001);
        check("R3 no update keeps rs", 32'(cmd_rs), 32'h1B);
        check("R3 no update keeps rw", 32'(cmd_rw), 0);
        update_ir = 1; cyc(); update_ir = 0;
        check("R3 update loads rs", 32'(cmd_rs), 32'h10);
        check("R4 rw field", 32'(cmd_rw), 1);
        check("R4 go/ex fields", {30'd0, cmd_go, cmd_ex}, 0);
        check("R5 cpu scan select", 32'(reg_sel), 32'h002);
        ir_scan({1'b0, 1'b1, 1'b0, 7'h05}, 1'b1, o);
        check("R2 second capture", 32'(o), 32'h001);
        check("R4 go field", {29'd0, cmd_rw, cmd_go, cmd_ex}, 32'b010);
    endtask

    task automatic t_decode_all();
        logic [9:0] o;
        for (int c = 0; c < 128; c++) begin
            ir_scan({3'b100, 7'(c)}, 1'b1, o);
            check($sformatf("R5 decode code %0h", c), 32'(reg_sel), 32'(exp_sel(7'(c))));
        end
    endtask

    task automatic t_bypass(input logic [6:0] code);
        logic [9:0]  o;
        logic [31:0] d;
        logic [3:0]  s1, s2;
        ir_scan({3'b100, code}, 1'b1, o);
        dr_scan(8, 32'hA5, d, s1, s2);
        check("R6 bypass delay", d, {23'd0, 8'hA5, 1'b0} & 32'hFF);
        check("R8 no strobe on bypass", 32'(s1), 0);
    endtask

    task automatic t_id_read_write();
        logic [9:0]  o;
        logic [31:0] d;
        logic [3:0]  s1, s2;
        ir_scan({3'b100, 7'h02}, 1'b1, o);
        dr_scan(32, 32'h0, d, s1, s2);
        check("R7 id value", d, IDV);
        check("R8 read strobe", 32'(s1), 32'b1000);
        check("R8 read strobe one cycle", 32'(s2), 0);
        ir_scan({3'b000, 7'h02}, 1'b1, o);
        dr_scan(32, 32'hFFFF_FFFF, d, s1, s2);
        check("R10 no write to id", 32'(s1), 0);
        dr_scan(32, 32'h0, d, s1, s2);
        check("R10 id unchanged after write", d, IDV);
    endtask

    task automatic t_ext_access();
        logic [9:0]  o;
        logic [31:0] d;
        logic [3:0]  s1, s2;
        ext_tdo = 1'b1;
        ir_scan({3'b000, 7'h21}, 1'b1, o);
        check("R5 iac2 select", 32'(reg_sel), 32'h010);
        dr_scan(8, 32'h00, d, s1, s2);
        check("R12 ext tdo passthrough", d, 32'hFF);
        check("R8 write strobe", 32'(s1), 32'b0100);
        check("R8 write strobe one cycle", 32'(s2), 0);
        ext_tdo = 1'b0;
        ir_scan({3'b100, 7'h26}, 1'b1, o);
        dr_scan(4, 32'h0, d, s1, s2);
        check("R8 read strobe dvc", 32'(s1), 32'b1000);
    endtask

    task automatic t_go_exit();
        logic [9:0]  o;
        logic [31:0] d;
        logic [3:0]  s1, s2;
        ir_scan({3'b011, 7'h11}, 1'b1, o);
        check("R9 no pulse at update-ir", 32'(stb_now()), 0);
        dr_scan(1, 32'h0, d, s1, s2);
        check("R9 go and exit pulse", 32'(s1), 32'b0011);
        check("R9 pulse one cycle", 32'(s2), 0);
        dr_scan(1, 32'h0, d, s1, s2);
        check("R11 repeat pulses", 32'(s1), 32'b0011);
        ir_scan({3'b010, 7'h40}, 1'b1, o);
        dr_scan(1, 32'h0, d, s1, s2);
        check("R9 go on reserved code", 32'(s1), 32'b0010);
        ir_scan({3'b101, 7'h12}, 1'b1, o);
        dr_scan(2, 32'h0, d, s1, s2);
        check("R9 read plus exit", 32'(s1), 32'b1001);
        dr_scan(2, 32'h0, d, s1, s2);
        check("R11 repeat read plus exit", 32'(s1), 32'b1001);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge tck);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_ir_capture_and_hold();
        t_decode_all();
        t_bypass(7'h11);
        t_bypass(7'h05);
        t_bypass(7'h7F);
        t_id_read_write();
        t_ext_access();
        t_go_exit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule